// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block sits between a host processor bus and a raw 8-bit NAND flash device. The host sees a single 32-bit word. A write to that word names an operation, the requested chip-enable level and a byte, and the bridge turns it into one timed strobe cycle on the flash pins. The pins are command latch, address latch, write strobe, read strobe, chip enable and the byte-wide I/O lanes. A read of the word returns the most recently captured flash byte and a synchronized busy flag.

A read-arm operation puts the bridge into streaming mode. In that mode every host read runs its own read-strobe cycle, so a run of N host reads drains N successive bytes from the device. Each host access is held off by a request/acknowledge handshake until the flash cycle, including its hold time, has finished. The setup, low and hold times of the strobes are cycle-count parameters.

Top module: `nand_reg_bridge`

## Requirements
- R1: A written word is decoded as follows. Bits 30:28 select the operation: 0 is a command byte, 1 an address byte, 2 arms streaming reads, 3 a data byte write. Bits 23:16 carry the byte for the flash I/O lanes.
- R2: A command cycle holds the command latch high and the address latch low from setup through hold, with the byte on the I/O lanes. An address cycle does the same with the two latches swapped.
- R3: A data write (operation 3) produces exactly one write-strobe pulse carrying the byte, with both latch lines low.
- R4: For operations 0 to 3, bit 31 of the written word sets the chip-enable pin: 1 drives it low and 0 drives it high. The level holds until the next such write.
- R5: While streaming is armed, each host read performs one read-strobe pulse and returns the captured byte in bits 23:16. Consecutive reads return consecutive flash bytes.
- R6: When streaming is not armed, a host read performs no strobe and returns the previously captured byte. Any command, address or data write disarms streaming.
- R7: Bit 15 of the read word is 1 while the ready/busy input is low. The input passes through two flip-flops, so a change shows on the second clock edge.
- R8: Each strobe cycle has T_SETUP cycles of setup and T_PULSE cycles with the strobe low, then T_HOLD cycles of hold. The latch lines and I/O byte stay stable across both edges of the strobe.
- R9: The acknowledge is a one-cycle pulse. For a strobed access it comes T_SETUP+T_PULSE+T_HOLD+1 clock edges after the request is first sampled. For an access with no strobe it comes one edge after.
- R10: The I/O output enable is high only during command, address and data-write cycles. It is never high while the read strobe is low.
- R11: Operations 4 to 7 are ignored. They produce no strobe and leave the chip enable and the streaming mode unchanged, and they are acknowledged after one edge.
- R12: After reset, chip enable, write strobe and read strobe are high, both latch lines are low, the I/O lanes are released and streaming is disarmed.
- R13: The write and read strobes are never low together, and the two latch lines are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Host access request, held until acknowledge |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_wdata | input | 32 | Host write word |
| bus_rdata | output | 32 | Host read word (byte in 23:16, busy in 15) |
| bus_ack | output | 1 | One-cycle access completion |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Byte driven onto the flash I/O lanes |
| nf_io_oe | output | 1 | Output enable for the I/O lanes |
| nf_io_in | input | 8 | Byte read from the flash I/O lanes |
| nf_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The bench streams three bytes after one arm. A design that captured once per arm, instead of once per read, would return the same byte repeatedly. It then sends an ignored opcode between streaming reads. A bridge that decoded opcodes 4 to 7 as real ones would strobe, release chip enable or drop streaming mode.

A command issued with chip enable clear checks both the pin level and the disarming of streaming. A bridge that kept streaming would strobe on the next read, and one that ignored the bit would keep the pin low. Acknowledge latencies and the widths of the strobe low times are counted, which exposes off-by-one counter loads. The busy flag is sampled edge by edge to catch a synchronizer with a missing or extra stage.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int CE_BIT    = 31;
    localparam int OP_LSB    = 28;
    localparam int BYTE_LSB  = 16;
    localparam int BUSY_BIT  = 15;

    localparam logic [2:0] OP_CMD    = 3'd0;
    localparam logic [2:0] OP_ADDR   = 3'd1;
    localparam logic [2:0] OP_ARM    = 3'd2;
    localparam logic [2:0] OP_WDATA  = 3'd3;

    typedef enum logic [2:0] {
        CY_NONE, CY_CMD, CY_ADDR, CY_WDATA, CY_RDATA
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              ce_req;
        logic [2:0]        op;
        logic [BYTE_W-1:0] data;
    } host_word_t;

    function automatic host_word_t unpack_word(input logic [WORD_W-1:0] w);
        host_word_t r;
        r.ce_req = w[CE_BIT];
        r.op     = w[OP_LSB +: 3];
        r.data   = w[BYTE_LSB +: BYTE_W];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input logic [BYTE_W-1:0] b,
                                                      input logic busy);
        logic [WORD_W-1:0] r;
        r = '0;
        r[BYTE_LSB +: BYTE_W] = b;
        r[BUSY_BIT] = busy;
        return r;
    endfunction

    function automatic logic op_is_valid(input logic [2:0] op);
        return op <= OP_WDATA;
    endfunction

endpackage

// File: rtl/nb_sync.sv
module nb_sync #(
    parameter int  STAGES    = 2,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/nb_strobe_seq.sv
module nb_strobe_seq
    import nand_bridge_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 2,
    parameter int T_HOLD  = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  cyc_kind_e kind,
    output logic      idle,
    output logic      done,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic      io_oe,
    output logic      capture
);
    localparam int TMAX1 = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int TMAX  = (TMAX1 > T_HOLD) ? TMAX1 : T_HOLD;
    localparam int CW    = $clog2(TMAX + 1);

    seq_state_e    state;
    cyc_kind_e     kind_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind_q <= CY_NONE;
            cnt    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    kind_q <= kind;
                    if (kind == CY_NONE) state <= ST_DONE;
                    else begin
                        state <= ST_SETUP;
                        cnt   <= CW'(T_SETUP - 1);
                    end
                end
                ST_SETUP: if (cnt == '0) begin
                    state <= ST_PULSE;
                    cnt   <= CW'(T_PULSE - 1);
                end else cnt <= cnt - 1'b1;
                ST_PULSE: if (cnt == '0) begin
                    state <= ST_HOLD;
                    cnt   <= CW'(T_HOLD - 1);
                end else cnt <= cnt - 1'b1;
                ST_HOLD: if (cnt == '0) state <= ST_DONE;
                         else cnt <= cnt - 1'b1;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic active, is_write;
    always_comb begin
        active   = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
        is_write = (kind_q == CY_CMD) || (kind_q == CY_ADDR) || (kind_q == CY_WDATA);
        idle     = (state == ST_IDLE);
        done     = (state == ST_DONE);
        cle      = active && (kind_q == CY_CMD);
        ale      = active && (kind_q == CY_ADDR);
        we_n     = !((state == ST_PULSE) && is_write);
        re_n     = !((state == ST_PULSE) && (kind_q == CY_RDATA));
        io_oe    = active && is_write;
        capture  = (state == ST_PULSE) && (cnt == '0) && (kind_q == CY_RDATA);
    end
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
    import nand_bridge_pkg::*;
#(
    parameter int T_SETUP     = 2,
    parameter int T_PULSE     = 2,
    parameter int T_HOLD      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    output logic        nf_ce_n,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_io_out,
    output logic        nf_io_oe,
    input  logic [7:0]  nf_io_in,
    input  logic        nf_rb_n
);
    host_word_t  hw;
    cyc_kind_e   kind;
    logic        seq_idle, start, capture, rb_s;
    logic        armed;
    logic [7:0]  io_byte, rd_byte;

    assign hw    = unpack_word(bus_wdata);
    assign start = bus_req && seq_idle;

    always_comb begin
        kind = CY_NONE;
        if (!bus_wr) begin
            if (armed) kind = CY_RDATA;
        end else begin
            case (hw.op)
                OP_CMD:   kind = CY_CMD;
                OP_ADDR:  kind = CY_ADDR;
                OP_WDATA: kind = CY_WDATA;
                default:  kind = CY_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nf_ce_n <= 1'b1;
            armed   <= 1'b0;
            io_byte <= '0;
            rd_byte <= '0;
        end else begin
            if (start && bus_wr && op_is_valid(hw.op)) begin
                nf_ce_n <= !hw.ce_req;
                armed   <= (hw.op == OP_ARM);
                if (hw.op != OP_ARM) io_byte <= hw.data;
            end
            if (capture) rd_byte <= nf_io_in;
        end
    end

    nb_strobe_seq #(
        .T_SETUP (T_SETUP),
        .T_PULSE (T_PULSE),
        .T_HOLD  (T_HOLD)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .kind    (kind),
        .idle    (seq_idle),
        .done    (bus_ack),
        .cle     (nf_cle),
        .ale     (nf_ale),
        .we_n    (nf_we_n),
        .re_n    (nf_re_n),
        .io_oe   (nf_io_oe),
        .capture (capture)
    );

    nb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
        .clk (clk),
        .rst (rst),
        .d   (nf_rb_n),
        .q   (rb_s)
    );

    assign nf_io_out = io_byte;
    assign bus_rdata = pack_status(rd_byte, !rb_s);
endmodule

// File: rtl/nb_checker.sv
module nb_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_ack,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic [7:0] nf_io_out,
    input logic       nf_io_oe
);
    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n));

    assert_latch_excl_R13: assert property (@(posedge clk) disable iff (rst)
        !(nf_cle && nf_ale));

    assert_oe_not_reading_R10: assert property (@(posedge clk) disable iff (rst)
        nf_io_oe |-> nf_re_n);

    assert_we_setup_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(nf_we_n) |-> ($stable(nf_cle) && $stable(nf_ale) &&
                            $stable(nf_io_out) && nf_io_oe));

    assert_we_hold_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(nf_we_n) |-> ($stable(nf_cle) && $stable(nf_ale) &&
                            $stable(nf_io_out) && nf_io_oe));

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);
endmodule

bind nand_reg_bridge nb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ack   (bus_ack),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_io_out (nf_io_out),
    .nf_io_oe  (nf_io_oe)
);

// File: tb/tb_nand_reg_bridge.sv
module tb_nand_reg_bridge;
    localparam int TS = 2, TP = 2, TH = 2;
    localparam int LAT_STROBE = TS + TP + TH + 1;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_ack;
    logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]  nf_io_out, nf_io_in;
    logic        nf_rb_n = 1'b1;

    int checks = 0, fails = 0;
    int ptr = 0;
    int re_strobes = 0;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic [7:0] b;
        logic       ce_n;
    } we_item_t;
    we_item_t exp_q[$];

    always #10 clk = ~clk;

    nand_reg_bridge #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH)) dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
        .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb_n(nf_rb_n)
    );

    function automatic logic [7:0] fbyte(input int i);
        return 8'(32'h3C ^ (i * 29));
    endfunction

    assign nf_io_in = fbyte(ptr);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: flash model and write-strobe scoreboard
    int we_low = 0, re_low = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0] we_byte; logic we_cle, we_ale, we_ce_n;
    always @(negedge clk) begin
        if (!rst) begin
            if (!nf_we_n) begin
                we_low++;
                we_byte = nf_io_out; we_cle = nf_cle; we_ale = nf_ale; we_ce_n = nf_ce_n;
            end
            if (!nf_re_n) re_low++;
            if (nf_we_n && !prev_we) begin
                chk(we_low == TP, "R8 we low width", we_low, TP);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected write strobe", {we_cle, we_ale, we_byte}, 0);
                end else begin
                    we_item_t e;
                    e = exp_q.pop_front();
                    chk({we_cle, we_ale, we_byte, we_ce_n} == e,
                        "R2/R3/R4 write strobe contents",
                        {we_cle, we_ale, we_byte, we_ce_n}, e);
                end
                we_low = 0;
            end
            if (nf_re_n && !prev_re) begin
                chk(re_low == TP, "R8 re low width", re_low, TP);
                re_low = 0;
                re_strobes++;
                ptr++;
            end
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    task automatic access(input logic wr, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!bus_ack && lat < 100);
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    function automatic logic [31:0] wword(input logic ce, input logic [2:0] op,
                                          input logic [7:0] b);
        return {ce, op, 4'h0, b, 16'h0};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] rd;
        int lat, rs0, exp_ptr;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk({nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe} == 6'b111000,
            "R12 reset pins", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe}, 6'b111000);
        rst = 1'b0;
        @(negedge clk);
        access(1'b0, '0, rd, lat);
        chk(lat == 1 && re_strobes == 0, "R12 disarmed after reset", re_strobes, 0);

        // R1 R2 command cycle with chip enable
        exp_q.push_back('{1'b1, 1'b0, 8'h90, 1'b0});
        access(1'b1, wword(1'b1, 3'd0, 8'h90), rd, lat);
        chk(lat == LAT_STROBE, "R9 command latency", lat, LAT_STROBE);
        chk(nf_ce_n == 1'b0, "R4 chip enable low", nf_ce_n, 0);
        chk(nf_io_oe == 1'b0, "R10 lanes released when idle", nf_io_oe, 0);
        // R2 address cycle
        exp_q.push_back('{1'b0, 1'b1, 8'h00, 1'b0});
        access(1'b1, wword(1'b1, 3'd1, 8'h00), rd, lat);
        // R3 data write
        exp_q.push_back('{1'b0, 1'b0, 8'hA5, 1'b0});
        access(1'b1, wword(1'b1, 3'd3, 8'hA5), rd, lat);
        chk(lat == LAT_STROBE, "R3 data write latency", lat, LAT_STROBE);

        // R5 arm and stream three bytes
        rs0 = re_strobes;
        access(1'b1, wword(1'b1, 3'd2, 8'h00), rd, lat);
        chk(lat == 1 && re_strobes == rs0, "R9 arm is unstrobed", lat, 1);
        exp_ptr = ptr;
        for (int k = 0; k < 3; k++) begin
            access(1'b0, '0, rd, lat);
            chk(rd[23:16] == fbyte(exp_ptr), "R5 streamed byte", rd[23:16], fbyte(exp_ptr));
            chk(lat == LAT_STROBE, "R5 read latency", lat, LAT_STROBE);
            exp_ptr++;
        end
        chk(re_strobes == rs0 + 3, "R5 one strobe per read", re_strobes, rs0 + 3);

        // R11 ignored opcode
        rs0 = re_strobes;
        access(1'b1, wword(1'b0, 3'd5, 8'h77), rd, lat);
        chk(lat == 1 && re_strobes == rs0, "R11 no strobe", lat, 1);
        chk(nf_ce_n == 1'b0, "R11 chip enable unchanged", nf_ce_n, 0);
        access(1'b0, '0, rd, lat);
        chk(rd[23:16] == fbyte(exp_ptr), "R11 streaming kept", rd[23:16], fbyte(exp_ptr));
        exp_ptr++;

        // R4 R6 command with chip enable clear disarms
        exp_q.push_back('{1'b1, 1'b0, 8'hFF, 1'b1});
        access(1'b1, wword(1'b0, 3'd0, 8'hFF), rd, lat);
        chk(nf_ce_n == 1'b1, "R4 chip enable high", nf_ce_n, 1);
        rs0 = re_strobes;
        access(1'b0, '0, rd, lat);
        chk(lat == 1 && re_strobes == rs0, "R6 disarmed read unstrobed", re_strobes, rs0);
        chk(rd[23:16] == fbyte(exp_ptr - 1), "R6 stale byte", rd[23:16], fbyte(exp_ptr - 1));

        // R7 busy through synchronizer
        @(negedge clk);
        chk(bus_rdata[15] == 1'b0, "R7 ready reads 0", bus_rdata[15], 0);
        nf_rb_n = 1'b0;
        @(negedge clk);
        chk(bus_rdata[15] == 1'b0, "R7 one edge not yet", bus_rdata[15], 0);
        @(negedge clk);
        chk(bus_rdata[15] == 1'b1, "R7 busy after two edges", bus_rdata[15], 1);
        access(1'b0, '0, rd, lat);
        chk(rd[15] == 1'b1, "R7 busy via access", rd[15], 1);
        nf_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_rdata[15] == 1'b0, "R7 ready again", bus_rdata[15], 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2/R3 all write strobes seen", exp_q.size(), 0);
        summary();
    end
endmodule